// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

This block holds two down-counting interval timers behind a small byte-wide write port. Timer A takes a 10-bit preload split across two registers. Timer B takes an 8-bit preload. An internal prescaler produces a strobe every `STROBE_DIV` clocks. Timer A steps once per strobe, and timer B steps once per `B_RATIO` strobes.

A running timer counts down to expiry, reloads itself from its preload register and keeps going. When a timer expires while its interrupt enable is set, it raises a sticky flag. The interrupt line is high while either flag is set. Software clears a flag by writing a one to the matching clear bit in the control register.

A status byte reports both flags and passes through an external busy indication. Software starts a timer with a control write whose load bit is one. A control write whose load bit is zero stops the timer and zeroes its counter.

The register addresses are the values that the surrounding bus decode expects:

| Address | Contents |
|---|---|
| 0x24 | Timer A preload bits 9..2 |
| 0x25 | Timer A preload bits 1..0, in data bits 1..0 |
| 0x26 | Timer B preload |
| 0x27 | Control register |

The control register bits are:

| Bit | Function |
|---|---|
| 0 | Load A |
| 1 | Load B |
| 2 | Interrupt enable A |
| 3 | Interrupt enable B |
| 4 | Clear flag A |
| 5 | Clear flag B |
| 7:6 | Accepted but unused |

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, both timers are stopped with zero counters, both flags and both interrupt enables are 0, `irq` is 0, and `status` equals `{busy_in, 7'b0}`.
- R2: Timer A's preload is `{reg 0x24[7:0], reg 0x25[1:0]}`. Once started with preload P, it expires on its P-th A-step. A preload of 0 behaves like 1.
- R3: Timer B's preload is register 0x26. Timer B steps only on every `B_RATIO`-th prescaler strobe, and otherwise follows the same expiry rule as timer A.
- R4: The prescaler strobe occurs once every `STROBE_DIV` clocks from reset, whether or not a timer is running. Each running timer A steps on every strobe.
- R5: A write to 0x27 with a timer's load bit (bit 0 for A, bit 1 for B) at 0 zeroes that counter and stops it. This write takes priority over a step in the same cycle.
- R6: A write to 0x27 with a load bit at 1 marks the timer running. It copies the preload into the counter only if the counter is zero. When the counter is not zero, the count in progress carries on unchanged.
- R7: On expiry, a timer reloads from the value its preload register holds at that cycle and keeps running without any further write.
- R8: On expiry, a timer's flag is set only if its interrupt enable (bit 2 for A, bit 3 for B of the last 0x27 write) is 1. With the enable at 0, the timer still runs and reloads.
- R9: A write to 0x27 with bit 4 (A) or bit 5 (B) at 1 clears that flag. If the clear and an expiry fall in the same cycle, the clear wins and the flag is 0 afterwards.
- R10: `status` is bit 0 = flag A, bit 1 = flag B, bit 7 = `busy_in`, and bits 6..2 = 0. `irq` is the OR of the two flags.
- R11: Bits 7:6 of a control write have no effect, and writes to any address other than 0x24 to 0x27 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| busy_in | input | 1 | External busy indication, shown in status bit 7 |
| status | output | 8 | Flags and busy bit |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
Two functions can fall in the same cycle: an expiry, which sets a flag, and a control write carrying a flag-clear bit. A control write can also coincide with a counter step. The bench provokes both cases by issuing a control write with the clear bits on every clock through several full timer periods, so that some of those writes land exactly on expiry cycles. The behavioural reference model resolves each such cycle by the stated priorities, and `status` and `irq` are compared against it after every clock.

// File: rtl/dit_pkg.sv
// Package dit_pkg
// Purpose: shared register addresses and control bit positions for the dual
//          interval timer.
// Assumes: an 8-bit register address space decoded by the surrounding bus.
package dit_pkg;
    localparam logic [7:0] ADDR_PRE_A_HI = 8'h24;
    localparam logic [7:0] ADDR_PRE_A_LO = 8'h25;
    localparam logic [7:0] ADDR_PRE_B    = 8'h26;
    localparam logic [7:0] ADDR_CTRL     = 8'h27;

    localparam int CTL_LOAD_A = 0;
    localparam int CTL_LOAD_B = 1;
    localparam int CTL_EN_A   = 2;
    localparam int CTL_EN_B   = 3;
    localparam int CTL_CLR_A  = 4;
    localparam int CTL_CLR_B  = 5;

    localparam int PRE_A_W = 10;
    localparam int PRE_B_W = 8;

    // Decoded effect of one control write, per timer.
    typedef struct packed {
        logic ld_wr;   // control write happened
        logic ld_val;  // value of the load bit
        logic clr;     // flag clear request
    } tmr_cmd_t;
endpackage

// File: rtl/dit_prescaler.sv
// Module dit_prescaler
// Purpose: divides the clock into the step strobes of both timers. tick_a
//          fires once every STROBE_DIV clocks. tick_b fires on every B_RATIO-th
//          tick_a.
// Assumes: STROBE_DIV >= 1 and B_RATIO >= 2. Both run freely from reset.
module dit_prescaler #(
    parameter int STROBE_DIV = 32,
    parameter int B_RATIO    = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_a,
    output logic tick_b
);
    localparam int PW = $clog2(STROBE_DIV + 1);
    localparam int BW = $clog2(B_RATIO);
    localparam logic [PW-1:0] P_LAST = PW'(STROBE_DIV - 1);
    localparam logic [BW-1:0] B_LAST = BW'(B_RATIO - 1);

    logic [PW-1:0] pcnt;
    logic [BW-1:0] bcnt;

    // Combinational strobes from the divider state.
    assign tick_a = (pcnt == P_LAST);
    assign tick_b = tick_a && (bcnt == B_LAST);

    // Clock divider producing the timer A strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (tick_a) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    // Strobe divider producing the timer B strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bcnt <= '0;
        else if (tick_b) bcnt <= '0;
        else if (tick_a) bcnt <= bcnt + 1'b1;
    end

    // tick_b is only ever a subset of tick_a.
    AST_B_WITHIN_A: assert property (@(posedge clk) disable iff (!rst_n)
        tick_b |-> tick_a); // R3

    // Successive A strobes are never adjacent unless the divider is 1.
    AST_A_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_a && STROBE_DIV > 1) |=> !tick_a); // R4
endmodule

// File: rtl/dit_regfile.sv
// Module dit_regfile
// Purpose: holds both preload registers and the interrupt enables. Turns
//          control writes into one-cycle load and clear commands per timer.
// Assumes: at most one write per cycle. Control bits 7:6 are accepted and
//          dropped. Unknown addresses are ignored.
module dit_regfile
    import dit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [7:0]           wr_data,
    output logic [PRE_A_W-1:0]   pre_a,
    output logic [PRE_B_W-1:0]   pre_b,
    output logic                 en_a,
    output logic                 en_b,
    output tmr_cmd_t             cmd_a,
    output tmr_cmd_t             cmd_b
);
    logic [7:0] pre_a_hi;
    logic [1:0] pre_a_lo;
    logic       ctl_wr;

    // Address decode for the control register.
    assign ctl_wr = wr_en && (wr_addr == ADDR_CTRL);

    // Build the per-timer commands of the current control write.
    always_comb begin
        cmd_a.ld_wr  = ctl_wr;
        cmd_a.ld_val = wr_data[CTL_LOAD_A];
        cmd_a.clr    = ctl_wr && wr_data[CTL_CLR_A];
        cmd_b.ld_wr  = ctl_wr;
        cmd_b.ld_val = wr_data[CTL_LOAD_B];
        cmd_b.clr    = ctl_wr && wr_data[CTL_CLR_B];
    end

    assign pre_a = {pre_a_hi, pre_a_lo};

    // Preload register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_a_hi <= '0;
            pre_a_lo <= '0;
            pre_b    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PRE_A_HI: pre_a_hi <= wr_data;
                ADDR_PRE_A_LO: pre_a_lo <= wr_data[1:0];
                ADDR_PRE_B:    pre_b    <= wr_data;
                default: ;
            endcase
        end
    end

    // Interrupt enables, taken from every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_a <= 1'b0;
            en_b <= 1'b0;
        end else if (ctl_wr) begin
            en_a <= wr_data[CTL_EN_A];
            en_b <= wr_data[CTL_EN_B];
        end
    end

    // A write elsewhere leaves the timer B preload alone.
    AST_PRE_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_PRE_B) |=> $stable(pre_b)); // R11
endmodule

// File: rtl/dit_counter.sv
// Module dit_counter
// Purpose: one down-counting interval timer with run state, conditional load,
//          clear-and-stop, and automatic reload on expiry.
// Assumes: tick is a one-cycle strobe. A control write outranks a step in the
//          same cycle. A preload of 0 expires on every step.
module dit_counter
    import dit_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_cmd_t     cmd,
    input  logic [W-1:0] preload,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic         run;
    logic         do_clear;
    logic         do_load;

    // Control-write outcomes for this cycle.
    assign do_clear = cmd.ld_wr && !cmd.ld_val;
    assign do_load  = cmd.ld_wr && cmd.ld_val && (cnt == '0);

    // Expiry: a running timer steps from one or zero, unless a write takes over.
    assign expire = run && tick && (cnt <= ONE) && !do_clear && !do_load;

    // Counter value: clear, load, reload or step.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (do_clear)       cnt <= '0;
        else if (do_load)        cnt <= preload;
        else if (expire)         cnt <= preload;
        else if (run && tick)    cnt <= cnt - 1'b1;
    end

    // Run state follows the last written load bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         run <= 1'b0;
        else if (cmd.ld_wr) run <= cmd.ld_val;
    end

    AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> (cnt == '0) && !run); // R5

    AST_LOAD_NONZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ld_wr && cmd.ld_val && cnt != '0 && !(run && tick)) |=> $stable(cnt)); // R6

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(preload)) && run); // R7

    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cmd.ld_wr) |=> $stable(cnt)); // R5
endmodule

// File: rtl/dit_flags.sv
// Module dit_flags
// Purpose: the sticky expiry flags of both timers. A flag is set on expiry when
//          its enable is on, and cleared by request. The clear wins a tie.
// Assumes: expiry and clear inputs are one-cycle pulses. Index 0 is timer A.
module dit_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] expire,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] clear,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag with clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)                      flag[i] <= 1'b0;
            else if (clear[i])               flag[i] <= 1'b0;
            else if (expire[i] && enable[i]) flag[i] <= 1'b1;
        end

        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clear[i] |=> !flag[i]); // R9

        AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> ($past(enable[i]) && $past(expire[i]))); // R8
    end
endmodule

// File: rtl/dual_interval_timer.sv
// Module dual_interval_timer
// Purpose: top level of the two interval timers. Connects the register file,
//          the prescaler, two counters and the flag pair, and forms the status
//          byte and the interrupt line.
// Assumes: synchronous active-low reset. busy_in is already synchronous to clk.
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int STROBE_DIV = 32,
    parameter int B_RATIO    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       busy_in,
    output logic [7:0] status,
    output logic       irq
);
    logic [PRE_A_W-1:0] pre_a;
    logic [PRE_B_W-1:0] pre_b;
    logic               en_a, en_b;
    tmr_cmd_t           cmd_a, cmd_b;
    logic               tick_a, tick_b;
    logic               exp_a, exp_b;
    logic [1:0]         flag;

    dit_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pre_a(pre_a), .pre_b(pre_b), .en_a(en_a),
        .en_b(en_b), .cmd_a(cmd_a), .cmd_b(cmd_b)
    );

    dit_prescaler #(.STROBE_DIV(STROBE_DIV), .B_RATIO(B_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b)
    );

    dit_counter #(.W(PRE_A_W)) u_cnt_a (
        .clk(clk), .rst_n(rst_n), .tick(tick_a), .cmd(cmd_a),
        .preload(pre_a), .expire(exp_a)
    );

    dit_counter #(.W(PRE_B_W)) u_cnt_b (
        .clk(clk), .rst_n(rst_n), .tick(tick_b), .cmd(cmd_b),
        .preload(pre_b), .expire(exp_b)
    );

    dit_flags #(.N(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .expire({exp_b, exp_a}),
        .enable({en_b, en_a}), .clear({cmd_b.clr, cmd_a.clr}), .flag(flag)
    );

    // Status byte and interrupt line.
    assign status = {busy_in, 5'b0, flag};
    assign irq    = |flag;

    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_a.clr && cmd_b.clr) |=> !irq); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R1
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
    localparam int DIV   = 4;
    localparam int BRAT  = 16;
    localparam int LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       busy_in = 1'b0;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R1";

    dual_interval_timer #(.STROBE_DIV(DIV), .B_RATIO(BRAT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy_in(busy_in), .status(status), .irq(irq)
    );

    always #2 clk = ~clk;

    // Behavioural reference model
    int m_p, m_s, m_ca, m_cb, m_pa, m_pb;
    bit m_ra, m_rb, m_ea, m_eb, m_fa, m_fb;

    always @(posedge clk) begin
        bit ta, tb, cw, xa, xb, ora, orb;
        cycles++;
        if (!rst_n) begin
            m_p = 0; m_s = 0; m_ca = 0; m_cb = 0; m_pa = 0; m_pb = 0;
            m_ra = 0; m_rb = 0; m_ea = 0; m_eb = 0; m_fa = 0; m_fb = 0;
        end else begin
            ta = (m_p == DIV - 1);
            tb = ta && (m_s == BRAT - 1);
            cw = wr_en && wr_addr == 8'h27;
            ora = m_ra; orb = m_rb;
            xa = 0; xb = 0;
            // timer A
            if (cw && !wr_data[0]) begin m_ca = 0; m_ra = 0; end
            else if (cw && wr_data[0] && m_ca == 0) begin m_ca = m_pa; m_ra = 1; end
            else begin
                if (cw) m_ra = 1;
                if (ora && ta) begin
                    if (m_ca <= 1) begin xa = 1; m_ca = m_pa; end
                    else m_ca--;
                end
            end
            // timer B
            if (cw && !wr_data[1]) begin m_cb = 0; m_rb = 0; end
            else if (cw && wr_data[1] && m_cb == 0) begin m_cb = m_pb; m_rb = 1; end
            else begin
                if (cw) m_rb = 1;
                if (orb && tb) begin
                    if (m_cb <= 1) begin xb = 1; m_cb = m_pb; end
                    else m_cb--;
                end
            end
            // flags, clear first
            if (cw && wr_data[4]) m_fa = 0; else if (xa && m_ea) m_fa = 1;
            if (cw && wr_data[5]) m_fb = 0; else if (xb && m_eb) m_fb = 1;
            // register writes
            if (wr_en) begin
                if (wr_addr == 8'h24) m_pa = (m_pa & 3) | (int'(wr_data) << 2);
                if (wr_addr == 8'h25) m_pa = (m_pa & 1020) | int'(wr_data[1:0]);
                if (wr_addr == 8'h26) m_pb = int'(wr_data);
            end
            if (cw) begin m_ea = wr_data[2]; m_eb = wr_data[3]; end
            // prescaler
            if (tb) m_s = 0; else if (ta) m_s++;
            if (ta) m_p = 0; else m_p++;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [7:0] exp_st;
        if (rst_n) begin
            exp_st = {busy_in, 5'b0, m_fb, m_fa};
            checks++;
            if (status !== exp_st || irq !== (m_fa | m_fb)) begin
                failures++;
                $display("FAIL %s: status=%02h irq=%0b expected status=%02h irq=%0b at cycle %0d",
                         cur_req, status, irq, exp_st, m_fa | m_fb, cycles);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (LIMIT) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, cycles=%0d expected below %0d", cycles, LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, checked directly
        @(negedge clk);
        checks++;
        if (status !== 8'h00 || irq !== 1'b0) begin
            failures++;
            $display("FAIL R1: status=%02h irq=%0b expected status=00 irq=0", status, irq);
        end
        idle(20);

        // R2 and R4: timer A preload 5 = {0x01,2'b01}, running with enable
        cur_req = "R2";
        wr(8'h24, 8'h01);
        wr(8'h25, 8'hFD);
        wr(8'h27, 8'h05);
        idle(60);
        cur_req = "R4";
        wr(8'h27, 8'h15);
        idle(40);

        // R7: change preload mid-run, the reload takes the new value
        cur_req = "R7";
        wr(8'h24, 8'h00);
        wr(8'h25, 8'h03);
        idle(80);
        wr(8'h27, 8'h15);
        idle(30);

        // R5: stop A with a zero load bit
        cur_req = "R5";
        wr(8'h27, 8'h10);
        idle(80);

        // R3: timer B preload 2, A stopped
        cur_req = "R3";
        wr(8'h26, 8'h02);
        wr(8'h27, 8'h0A);
        idle(300);
        wr(8'h27, 8'h2A);
        idle(150);

        // R6: reload request while counting leaves the count alone
        cur_req = "R6";
        wr(8'h24, 8'h04);
        wr(8'h25, 8'h00);
        wr(8'h27, 8'h0F);
        idle(9);
        wr(8'h24, 8'h01);
        wr(8'h27, 8'h0F);
        idle(5);
        wr(8'h27, 8'h3F);
        idle(120);

        // R8: enables off, timers still run but no flags
        cur_req = "R8";
        wr(8'h27, 8'h33);
        idle(300);
        wr(8'h27, 8'h0F);
        idle(150);

        // R9: clear requests on every clock, some land on expiry cycles
        cur_req = "R9";
        wr(8'h24, 8'h00);
        wr(8'h25, 8'h00);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 8'h27; wr_data = (i % 2 == 0) ? 8'h3F : 8'h1F;
        end
        @(negedge clk);
        wr_en = 1'b0;
        idle(80);

        // R10: busy passthrough and status layout
        cur_req = "R10";
        busy_in = 1'b1;
        idle(40);
        busy_in = 1'b0;
        idle(10);

        // R11: bits 7:6 and foreign addresses change nothing
        cur_req = "R11";
        wr(8'h27, 8'hCF);
        wr(8'h20, 8'hFF);
        wr(8'h28, 8'hFF);
        wr(8'h23, 8'h00);
        idle(200);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule